// File: doc/BRIEF.md
# Access-Order Sequenced Math Coprocessor

This block is an arithmetic helper that sits on a CPU's byte-wide register bus. Software never writes an opcode. The block works out which operation to run from the order in which it touches two operand registers: the A port and the B port. The supported operations are:

- unsigned 16x16 multiply;
- 32/16 and 16/16 unsigned divide;
- 32-bit logical shift in either direction;
- 32-bit normalize.

A shift or normalize is launched by writing a configuration register after the operand. While operands are being loaded and while the operation runs, a busy flag is raised. When the operation finishes, the result is drained back out through the same ports, most significant byte first.

Each multiply result, and each quotient from a divide with a nonzero divisor, is added into a 40-bit running sum. Software can preload this sum, and later read it back, through a third byte port called the C port. This gives multiply-accumulate behaviour without spending extra cycles.

Any access to the A, B or C port that breaks the expected order puts the block into a stuck error state. Only an explicit clear through the status register releases it. Addresses outside the block's sequenced ports can be accessed freely in the middle of a sequence.

Top module: `seqmath_unit`

Register addresses: A port = 0, B port = 1, C port = 2, configuration (CFG) = 3, status (STAT) = 4. Addresses 5 to 7 are unrelated to the block.

STAT bits:
- bit 0: busy
- bit 1: divide-by-zero
- bit 2: sequence-corrupt
- bit 3: sequence-active, meaning the block is not idle

## Requirements
- R1: Multiply. Write the B port twice (multiplier, low byte then high byte), then the A port twice (multiplicand, low byte then high byte). This runs a 16x16 unsigned multiply. The 32-bit product is then read back with four A-port reads, most significant byte first.
- R2: 32/16 divide. Write the A port four times (dividend, low byte first), then the B port twice (divisor, low byte first). This runs a 32/16 divide. Read the 32-bit quotient with four A-port reads, then the 16-bit remainder with two B-port reads. Both come out most significant byte first.
- R3: 16/16 divide. Write the A port only twice before the two B-port writes. This runs a 16/16 divide, with the upper quotient bytes reading as zero.
- R4: Shift. Write the A port four times, then write CFG. CFG bit 6 = 0 selects a shift. Bit 5 sets the direction: 0 = left, 1 = right. Bits 4:0 give the shift count. The shifted value is read back through the A port, most significant byte first.
- R5: Normalize. Use the same load order as R4 with CFG bit 6 = 1. The block shifts the operand left until bit 31 is set. The mantissa is read back through the A port and the shift amount through CFG bits 4:0. A zero operand gives mantissa 0 and exponent 0.
- R6: Busy timing. Busy rises with the first operand write. After the final launching write, busy stays high for LONG_LAT cycles (default 9) for divide, shift and normalize, and for SHORT_LAT cycles (default 6) for multiply.
- R7: Out-of-order accesses. A read or write of the A or B port that the current step does not expect enters an error state, with STAT bit 2 and busy both set. Every later port access is ignored until STAT is written with bit 0 = 0, which returns the block to idle.
- R8: Accesses to addresses 5 to 7 have no effect on a sequence in progress. Neither do CFG reads, or STAT writes with bit 0 = 1.
- R9: C port. Five C-port writes load the 40-bit sum, low byte first. Five C-port reads return it, high byte first. A C-port access while STAT bit 3 is set counts as an out-of-order access and leaves the sum untouched.
- R10: Accumulation. Each product, and each quotient from a divide with a nonzero divisor, is added into the 40-bit sum modulo 2^40 when the operation completes.
- R11: Divide by zero. A divide with a zero divisor completes in the normal time. It returns quotient 0xFFFFFFFF and the low 16 dividend bits as remainder, sets STAT bit 1, and adds nothing to the sum.
- R12: After reset, busy is 0, STAT reads 0 and the 40-bit sum reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W (3) | Register address |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe; a read advances the sequence at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the same cycle as bus_rd |
| busy | output | 1 | Operation loading, running or stuck in error |

## Verification
The bench sweeps grids of operands for every operation and checks the results against arithmetic computed in the bench. A design that swapped byte order or dropped the upper dividend bytes would show up in the quotient and remainder, and one that miscounted the latency would show a wrong busy width.

Zero divisors fall inside the divide grids. This catches a design that traps, or that adds garbage into the sum. Deliberate order violations, C-port access during a sequence, and interleaved foreign accesses each probe the sequencer. A design that tolerated a wrong step would return a result, and one that lost its place on a foreign access would corrupt one.

A preload near 2^40 shows whether the sum wraps correctly.

// File: rtl/seqmath_pkg.sv
// Shared constants and types for the sequenced math coprocessor.
// Assumes an 8-bit data bus and a 3-bit register address.
package seqmath_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] RA_A    = 3'd0;
    localparam logic [ADDR_W-1:0] RA_B    = 3'd1;
    localparam logic [ADDR_W-1:0] RA_C    = 3'd2;
    localparam logic [ADDR_W-1:0] RA_CFG  = 3'd3;
    localparam logic [ADDR_W-1:0] RA_STAT = 3'd4;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LDA,
        ST_LDB_DIV,
        ST_LDB_MUL,
        ST_LDA_MUL,
        ST_RUN,
        ST_RDA,
        ST_RDB,
        ST_BAD
    } seq_state_t;

    typedef enum logic [2:0] {
        OP_MUL,
        OP_DIV16,
        OP_DIV32,
        OP_SHIFT,
        OP_NORM
    } op_t;

    typedef struct packed {
        logic [31:0] q;
        logic [15:0] r;
        logic [4:0]  e;
        logic        dz;
    } alu_out_t;

endpackage

// File: rtl/seqmath_alu.sv
// Combinational datapath: multiply, divide, shift and normalize on the
// captured operands. Assumes the operands stay stable while the sequencer
// runs its latency timer; the result is sampled once, at completion.
module seqmath_alu
    import seqmath_pkg::*;
(
    input  op_t         op,
    input  logic [31:0] a_op,
    input  logic [15:0] b_op,
    input  logic [5:0]  shcfg,
    output alu_out_t    res
);

    logic [31:0] dvs;
    logic [31:0] rem_full;
    logic [4:0]  lz;
    logic        found;

    // Purpose: count the leading zeros of the operand for normalize.
    always_comb begin
        lz    = 5'd0;
        found = 1'b0;
        for (int i = 31; i >= 0; i--) begin
            if (!found && a_op[i]) begin
                lz    = 5'(31 - i);
                found = 1'b1;
            end
        end
    end

    // Purpose: select and compute the result of the chosen operation.
    always_comb begin
        res      = '0;
        dvs      = {16'b0, b_op};
        rem_full = '0;
        unique case (op)
            OP_MUL: begin
                res.q = 32'(a_op[15:0]) * 32'(b_op);
            end
            OP_DIV16, OP_DIV32: begin
                if (b_op == 16'd0) begin
                    res.q  = '1;
                    res.r  = a_op[15:0];
                    res.dz = 1'b1;
                end else begin
                    res.q    = a_op / dvs;
                    rem_full = a_op % dvs;
                    res.r    = rem_full[15:0];
                end
            end
            OP_SHIFT: begin
                res.q = shcfg[5] ? (a_op >> shcfg[4:0]) : (a_op << shcfg[4:0]);
            end
            OP_NORM: begin
                res.q = a_op << lz;
                res.e = lz;
            end
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/seqmath_acc.sv
// 40-bit running sum with byte-serial load (low byte first) and readback
// (high byte first). Assumes the caller gates wr/rd so they never coincide
// with add_en.
module seqmath_acc #(
    parameter int ACC_W = 40
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr_ptr,
    input  logic        wr,
    input  logic        rd,
    input  logic [7:0]  wdata,
    input  logic        add_en,
    input  logic [31:0] add_val,
    output logic [7:0]  rdata
);

    localparam int NB = ACC_W / 8;
    localparam int PW = $clog2(NB);
    localparam logic [PW-1:0] LAST = PW'(NB - 1);

    logic [ACC_W-1:0] sum_q;
    logic [PW-1:0]    wp;
    logic [PW-1:0]    rp;

    // Purpose: byte loads, accumulation and pointer movement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q <= '0;
            wp    <= '0;
            rp    <= '0;
        end else if (clr_ptr) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (add_en) begin
                sum_q <= sum_q + ACC_W'(add_val);
            end else if (wr) begin
                sum_q[8*wp +: 8] <= wdata;
            end
            if (wr) begin
                wp <= (wp == LAST) ? '0 : wp + PW'(1);
            end
            if (rd) begin
                rp <= (rp == LAST) ? '0 : rp + PW'(1);
            end
        end
    end

    // Purpose: present the byte selected by the read pointer, high byte first.
    always_comb begin
        rdata = 8'(sum_q >> (8 * (NB - 1 - int'(rp))));
    end

endmodule

// File: rtl/seqmath_seq.sv
// Access-order sequencer. Decodes the operation from the order of A/B port
// writes, captures operands, times the run, latches results and tracks
// readback. Any unexpected A/B/C port access parks it in ST_BAD until a
// STAT write with bit 0 clear. Assumes one bus access per cycle.
module seqmath_seq
    import seqmath_pkg::*;
#(
    parameter int LONG_LAT  = 9,
    parameter int SHORT_LAT = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [7:0]        wdata,
    input  alu_out_t          alu_res,
    output seq_state_t        state,
    output op_t               op,
    output logic [2:0]        cnt,
    output logic [31:0]       a_buf,
    output logic [15:0]       b_buf,
    output logic [7:0]        cfg,
    output logic [31:0]       res_q,
    output logic [15:0]       res_r,
    output logic              dz_flag,
    output logic              abort,
    output logic              add_en
);

    localparam int MAXL = (LONG_LAT > SHORT_LAT) ? LONG_LAT : SHORT_LAT;
    localparam int TW   = $clog2(MAXL + 1);

    logic [TW-1:0] timer;
    logic a_w, a_r, b_w, b_r, cfg_w, mc_any, is_div, finishing;

    // Purpose: decode the bus strobes for each register.
    always_comb begin
        a_w    = wr && (addr == RA_A);
        a_r    = rd && (addr == RA_A);
        b_w    = wr && (addr == RA_B);
        b_r    = rd && (addr == RA_B);
        cfg_w  = wr && (addr == RA_CFG);
        mc_any = (wr || rd) && (addr == RA_C);
        abort  = wr && (addr == RA_STAT) && !wdata[0];
        is_div = (op == OP_DIV16) || (op == OP_DIV32);
        finishing = (state == ST_RUN) && (timer == TW'(1))
                    && !(a_w || a_r || b_w || b_r || mc_any);
        add_en = finishing && (op == OP_MUL || (is_div && !alu_res.dz));
    end

    // Purpose: step the sequence, capture operands and latch results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            op      <= OP_MUL;
            cnt     <= '0;
            a_buf   <= '0;
            b_buf   <= '0;
            cfg     <= '0;
            res_q   <= '0;
            res_r   <= '0;
            dz_flag <= 1'b0;
            timer   <= '0;
        end else if (abort) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            dz_flag <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (cfg_w) cfg <= wdata;
                    if (a_w) begin
                        a_buf   <= {24'b0, wdata};
                        cnt     <= 3'd1;
                        dz_flag <= 1'b0;
                        state   <= ST_LDA;
                    end else if (b_w) begin
                        b_buf   <= {8'b0, wdata};
                        cnt     <= 3'd1;
                        dz_flag <= 1'b0;
                        state   <= ST_LDB_MUL;
                    end else if (a_r || b_r) begin
                        state <= ST_BAD;
                    end
                end
                ST_LDA: begin
                    if (a_w) begin
                        if (cnt < 3'd4) begin
                            a_buf[8*cnt +: 8] <= wdata;
                            cnt <= cnt + 3'd1;
                        end else begin
                            state <= ST_BAD;
                        end
                    end else if (b_w) begin
                        if (cnt == 3'd2 || cnt == 3'd4) begin
                            b_buf <= {8'b0, wdata};
                            op    <= (cnt == 3'd2) ? OP_DIV16 : OP_DIV32;
                            state <= ST_LDB_DIV;
                        end else begin
                            state <= ST_BAD;
                        end
                    end else if (cfg_w) begin
                        cfg <= wdata;
                        if (cnt == 3'd4) begin
                            op    <= wdata[6] ? OP_NORM : OP_SHIFT;
                            timer <= TW'(LONG_LAT);
                            state <= ST_RUN;
                        end
                    end else if (a_r || b_r || mc_any) begin
                        state <= ST_BAD;
                    end
                end
                ST_LDB_DIV: begin
                    if (b_w) begin
                        b_buf[15:8] <= wdata;
                        timer       <= TW'(LONG_LAT);
                        state       <= ST_RUN;
                    end else if (a_w || a_r || b_r || mc_any) begin
                        state <= ST_BAD;
                    end
                end
                ST_LDB_MUL: begin
                    if (b_w && cnt == 3'd1) begin
                        b_buf[15:8] <= wdata;
                        cnt         <= 3'd2;
                    end else if (a_w && cnt == 3'd2) begin
                        a_buf <= {24'b0, wdata};
                        op    <= OP_MUL;
                        state <= ST_LDA_MUL;
                    end else if (a_w || b_w || a_r || b_r || mc_any) begin
                        state <= ST_BAD;
                    end
                end
                ST_LDA_MUL: begin
                    if (a_w) begin
                        a_buf[15:8] <= wdata;
                        timer       <= TW'(SHORT_LAT);
                        state       <= ST_RUN;
                    end else if (b_w || a_r || b_r || mc_any) begin
                        state <= ST_BAD;
                    end
                end
                ST_RUN: begin
                    if (a_w || b_w || a_r || b_r || mc_any) begin
                        state <= ST_BAD;
                    end else if (finishing) begin
                        res_q   <= alu_res.q;
                        res_r   <= alu_res.r;
                        dz_flag <= alu_res.dz;
                        if (op == OP_NORM) cfg[4:0] <= alu_res.e;
                        cnt     <= '0;
                        state   <= ST_RDA;
                    end else begin
                        timer <= timer - TW'(1);
                    end
                end
                ST_RDA: begin
                    if (a_r) begin
                        if (cnt == 3'd3) begin
                            cnt   <= '0;
                            state <= is_div ? ST_RDB : ST_IDLE;
                        end else begin
                            cnt <= cnt + 3'd1;
                        end
                    end else if (a_w || b_w || b_r || mc_any) begin
                        state <= ST_BAD;
                    end
                end
                ST_RDB: begin
                    if (b_r) begin
                        if (cnt == 3'd1) begin
                            cnt   <= '0;
                            state <= ST_IDLE;
                        end else begin
                            cnt <= 3'd1;
                        end
                    end else if (a_w || b_w || a_r || mc_any) begin
                        state <= ST_BAD;
                    end
                end
                ST_BAD: state <= ST_BAD;
                default: state <= ST_BAD;
            endcase
        end
    end

endmodule

// File: rtl/seqmath_unit.sv
// Top of the sequenced math coprocessor: wires the sequencer, datapath and
// 40-bit sum, and multiplexes read data. Assumes reads are combinational and
// that a read's side effect (pointer advance) takes place at the clock edge.
module seqmath_unit
    import seqmath_pkg::*;
#(
    parameter int LONG_LAT  = 9,
    parameter int SHORT_LAT = 6,
    parameter int ACC_W     = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              busy
);

    seq_state_t  state;
    op_t         op;
    logic [2:0]  cnt;
    logic [31:0] a_buf;
    logic [15:0] b_buf;
    logic [7:0]  cfg;
    logic [31:0] res_q;
    logic [15:0] res_r;
    logic        dz_flag;
    logic        bad_flag;
    logic        abort;
    logic        add_en;
    alu_out_t    alu_res;
    logic        acc_wr, acc_rd;
    logic [7:0]  acc_rdata;
    logic [7:0]  stat_byte;

    seqmath_seq #(
        .LONG_LAT  (LONG_LAT),
        .SHORT_LAT (SHORT_LAT)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (bus_addr),
        .wr      (bus_wr),
        .rd      (bus_rd),
        .wdata   (bus_wdata),
        .alu_res (alu_res),
        .state   (state),
        .op      (op),
        .cnt     (cnt),
        .a_buf   (a_buf),
        .b_buf   (b_buf),
        .cfg     (cfg),
        .res_q   (res_q),
        .res_r   (res_r),
        .dz_flag (dz_flag),
        .abort   (abort),
        .add_en  (add_en)
    );

    seqmath_alu u_alu (
        .op    (op),
        .a_op  (a_buf),
        .b_op  (b_buf),
        .shcfg (cfg[5:0]),
        .res   (alu_res)
    );

    seqmath_acc #(
        .ACC_W (ACC_W)
    ) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_ptr (abort),
        .wr      (acc_wr),
        .rd      (acc_rd),
        .wdata   (bus_wdata),
        .add_en  (add_en),
        .add_val (alu_res.q),
        .rdata   (acc_rdata)
    );

    // Purpose: derive flags and gate the C port to the idle state.
    always_comb begin
        bad_flag  = (state == ST_BAD);
        busy      = (state != ST_IDLE) && (state != ST_RDA) && (state != ST_RDB);
        acc_wr    = bus_wr && (bus_addr == RA_C) && (state == ST_IDLE);
        acc_rd    = bus_rd && (bus_addr == RA_C) && (state == ST_IDLE);
        stat_byte = {4'b0, state != ST_IDLE, bad_flag, dz_flag, busy};
    end

    // Purpose: read data multiplexer.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (bus_addr)
                RA_A:    if (state == ST_RDA) bus_rdata = 8'(res_q >> (8 * (3 - int'(cnt))));
                RA_B:    if (state == ST_RDB) bus_rdata = (cnt == 3'd0) ? res_r[15:8] : res_r[7:0];
                RA_C:    if (state == ST_IDLE) bus_rdata = acc_rdata;
                RA_CFG:  bus_rdata = cfg;
                RA_STAT: bus_rdata = stat_byte;
                default: bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/seqmath_chk.sv
// Protocol checker for seqmath_unit, attached by bind. Observes the bus
// ports, busy and the internal flags only.
module seqmath_chk
    import seqmath_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [7:0]        bus_wdata,
    input logic              busy,
    input logic              dz_flag,
    input logic              bad_flag
);

    // R6, R7: busy only rises after an A or B port access.
    p_rise_from_port_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(bus_wr || bus_rd) &&
                         ($past(bus_addr) == RA_A || $past(bus_addr) == RA_B)));

    // R7: the error state always holds busy.
    p_bad_holds_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bad_flag |-> busy);

    // R7: a clearing STAT write returns to idle.
    p_abort_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == RA_STAT && !bus_wdata[0]) |=> (!busy && !bad_flag));

    // R9: C port access during a busy sequence corrupts it.
    p_mc_while_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (bus_wr || bus_rd) && bus_addr == RA_C) |=> bad_flag);

    // R11: a divide-by-zero flag appears only as the operation completes.
    p_dz_at_finish_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dz_flag) |-> $fell(busy));

    // R12: reset leaves the block idle.
    p_reset_idle_r12: assert property (@(posedge clk)
        !rst_n |=> (!busy && !bad_flag && !dz_flag));

endmodule

bind seqmath_unit seqmath_chk u_seqmath_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .busy      (busy),
    .dz_flag   (dz_flag),
    .bad_flag  (bad_flag)
);

// File: tb/test_seqmath_unit.sv
// Self-checking bench: operand sweeps for every operation, sequencing faults
// and accumulator behaviour, with expected values computed arithmetically.
module test_seqmath_unit;

    localparam int LONG_LAT  = 9;
    localparam int SHORT_LAT = 6;
    localparam logic [2:0] A = 3'd0, B = 3'd1, C = 3'd2, CF = 3'd3, ST = 3'd4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       busy;

    int errors = 0;
    int checks = 0;
    bit finished = 0;
    logic [39:0] acc_exp = '0;

    seqmath_unit #(.LONG_LAT(LONG_LAT), .SHORT_LAT(SHORT_LAT)) i_seqmath_unit (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_op(input logic [2:0] a, input bit w, input logic [7:0] d, output logic [7:0] q);
        @(negedge clk);
        bus_addr = a; bus_wr = w; bus_rd = !w; bus_wdata = d;
        #2 q = bus_rdata;
        @(posedge clk);
        #1 bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic wr8(input logic [2:0] a, input logic [7:0] d);
        logic [7:0] dummy;
        bus_op(a, 1'b1, d, dummy);
    endtask

    task automatic rd8(input logic [2:0] a, output logic [7:0] q);
        bus_op(a, 1'b0, 8'h00, q);
    endtask

    task automatic latency(output int n);
        n = 0;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (!busy) break;
            n++;
        end
    endtask

    task automatic rd_a32(output logic [31:0] v);
        logic [7:0] b8;
        v = '0;
        for (int k = 0; k < 4; k++) begin
            rd8(A, b8);
            v = {v[23:0], b8};
        end
    endtask

    task automatic acc_read(output logic [39:0] v);
        logic [7:0] b8;
        v = '0;
        for (int k = 0; k < 5; k++) begin
            rd8(C, b8);
            v = {v[31:0], b8};
        end
    endtask

    task automatic acc_load(input logic [39:0] v);
        for (int k = 0; k < 5; k++) wr8(C, v[8*k +: 8]);
    endtask

    task automatic run_mul(input logic [15:0] x, input logic [15:0] y);
        int n;
        logic [31:0] p;
        wr8(B, y[7:0]); wr8(B, y[15:8]);
        wr8(A, x[7:0]); wr8(A, x[15:8]);
        latency(n);
        chk(n == SHORT_LAT, "R6 multiply busy cycles", 64'(n), 64'(SHORT_LAT));
        rd_a32(p);
        chk(p == 32'(x) * 32'(y), "R1 product", 64'(p), 64'(32'(x) * 32'(y)));
        acc_exp = acc_exp + 40'(32'(x) * 32'(y));
    endtask

    task automatic run_div(input logic [31:0] x, input logic [15:0] y, input bit wide, input bit noise);
        int n;
        logic [31:0] q, qe;
        logic [15:0] re;
        logic [7:0] b8, s8;
        logic [31:0] xx;
        string tq;
        xx = wide ? x : {16'b0, x[15:0]};
        tq = wide ? "R2 quotient" : "R3 quotient";
        wr8(A, xx[7:0]);
        if (noise) begin wr8(3'd5, 8'hA5); rd8(3'd6, b8); wr8(ST, 8'h01); rd8(CF, b8); end
        wr8(A, xx[15:8]);
        if (wide) begin wr8(A, xx[23:16]); wr8(A, xx[31:24]); end
        if (noise) wr8(3'd7, 8'h3C);
        wr8(B, y[7:0]); wr8(B, y[15:8]);
        latency(n);
        chk(n == LONG_LAT, "R6 divide busy cycles", 64'(n), 64'(LONG_LAT));
        rd8(ST, s8);
        if (y == 16'd0) begin
            qe = '1; re = xx[15:0];
            chk(s8[1] == 1'b1, "R11 divide-by-zero flag", 64'(s8), 64'h2);
        end else begin
            qe = xx / {16'b0, y}; re = 16'(xx % {16'b0, y});
            chk(s8[1] == 1'b0, "R11 no flag on nonzero divisor", 64'(s8), 64'h0);
            acc_exp = acc_exp + 40'(qe);
        end
        rd_a32(q);
        chk(q == qe, noise ? "R8 quotient with foreign accesses" : tq, 64'(q), 64'(qe));
        rd8(B, b8); q = {24'b0, b8};
        rd8(B, b8); q = {q[23:0], b8};
        chk(q[15:0] == re, wide ? "R2 remainder" : "R3 remainder", 64'(q[15:0]), 64'(re));
    endtask

    task automatic run_shift(input logic [31:0] x, input logic [7:0] cfgv,
                             input logic [31:0] exp_v, input logic [4:0] exp_e, input string tag);
        int n;
        logic [31:0] v;
        logic [7:0] c8;
        wr8(A, x[7:0]); wr8(A, x[15:8]); wr8(A, x[23:16]); wr8(A, x[31:24]);
        wr8(CF, cfgv);
        latency(n);
        chk(n == LONG_LAT, "R6 shift/normalize busy cycles", 64'(n), 64'(LONG_LAT));
        rd_a32(v);
        chk(v == exp_v, tag, 64'(v), 64'(exp_v));
        if (cfgv[6]) begin
            rd8(CF, c8);
            chk(c8[4:0] == exp_e, "R5 exponent", 64'(c8[4:0]), 64'(exp_e));
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        logic [7:0]  s8;
        logic [39:0] av;
        logic [31:0] v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R12: reset state
        @(negedge clk);
        chk(busy == 1'b0, "R12 busy after reset", 64'(busy), 64'h0);
        rd8(ST, s8);
        chk(s8 == 8'h00, "R12 status after reset", 64'(s8), 64'h0);
        acc_read(av);
        chk(av == 40'h0, "R12 sum after reset", 64'(av), 64'h0);

        // R9: load and read back the sum
        acc_load(40'hA1_B2C3_D4E5);
        acc_read(av);
        chk(av == 40'hA1_B2C3_D4E5, "R9 sum load/readback", 64'(av), 64'hA1B2C3D4E5);
        acc_exp = 40'hA1_B2C3_D4E5;

        // R1: multiply grid
        for (int i = 0; i < 16; i++)
            for (int j = 0; j < 16; j++)
                run_mul(16'(i * 16'h1111 + (i >> 1)), 16'(j * 16'h0F0F + j));

        // R2 / R11: 32/16 divide grid, j=0 gives a zero divisor
        for (int i = 0; i < 16; i++)
            for (int j = 0; j < 16; j++)
                run_div(32'(i) * 32'h1234_5679 ^ 32'(j), 16'(j * 16'h1111 + (j >> 1)), 1'b1, 1'b0);

        // R3: 16/16 divide grid
        for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++)
                run_div(32'(i * 16'h2345 + 7), 16'(j * 16'h0123), 1'b0, 1'b0);

        // R10: sum after all operations
        acc_read(av);
        chk(av == acc_exp, "R10 accumulated sum", 64'(av), 64'(acc_exp));

        // R4: shifts in both directions, every count
        for (int k = 0; k < 32; k++) begin
            run_shift(32'h8421_F00D, 8'(k), 32'h8421_F00D << k, 5'd0, "R4 left shift");
            run_shift(32'h8421_F00D, 8'(32 + k), 32'h8421_F00D >> k, 5'd0, "R4 right shift");
        end

        // R5: normalize with leading one at every position, plus zero
        for (int k = 0; k < 32; k++) begin
            v = (32'd1 << k) | 32'(k >> 1);
            run_shift(v, 8'h40, v << (31 - k), 5'(31 - k), "R5 mantissa");
        end
        run_shift(32'h0, 8'h40, 32'h0, 5'd0, "R5 zero mantissa");

        // R8: foreign accesses between steps
        run_div(32'hDEAD_BEEF, 16'h0123, 1'b1, 1'b1);

        // R10: shift/normalize add nothing; wrap modulo 2^40
        acc_read(av);
        chk(av == acc_exp, "R10 sum unchanged by shift/normalize", 64'(av), 64'(acc_exp));
        acc_load(40'hFF_FFFF_FFFE);
        acc_exp = 40'hFF_FFFF_FFFE;
        run_mul(16'd3, 16'd1);
        acc_read(av);
        chk(av == 40'h1, "R10 sum wraps", 64'(av), 64'h1);

        // R7: read of B port in idle corrupts
        rd8(B, s8);
        @(negedge clk);
        chk(busy == 1'b1, "R7 busy held after bad access", 64'(busy), 64'h1);
        rd8(ST, s8);
        chk(s8[2] == 1'b1, "R7 corrupt flag", 64'(s8), 64'h0D);
        wr8(B, 8'h02); wr8(B, 8'h00); wr8(A, 8'h03); wr8(A, 8'h00);
        repeat (12) @(negedge clk);
        chk(busy == 1'b1, "R7 stuck until cleared", 64'(busy), 64'h1);
        wr8(ST, 8'h00);
        @(negedge clk);
        chk(busy == 1'b0, "R7 clear returns to idle", 64'(busy), 64'h0);
        rd8(ST, s8);
        chk(s8 == 8'h00, "R7 status clean after clear", 64'(s8), 64'h0);
        run_mul(16'd7, 16'd9);

        // R7: B write after three A writes corrupts
        wr8(A, 8'h11); wr8(A, 8'h22); wr8(A, 8'h33); wr8(B, 8'h01);
        rd8(ST, s8);
        chk(s8[2] == 1'b1, "R7 B after three A bytes", 64'(s8), 64'h0D);
        wr8(ST, 8'h00);

        // R9: C port during a sequence corrupts and leaves sum alone
        acc_read(av);
        acc_exp = av;
        wr8(A, 8'h01);
        wr8(C, 8'h77);
        rd8(ST, s8);
        chk(s8[2] == 1'b1, "R9 C access while active", 64'(s8), 64'h0D);
        wr8(ST, 8'h00);
        acc_read(av);
        chk(av == acc_exp, "R9 sum untouched", 64'(av), 64'(acc_exp));

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule